// File: doc/BRIEF.md
# Multiprocessor Address Recognition Filter

This block follows a 9-bit serial receiver on a shared multidrop line. Each received frame comes with a ninth bit. A ninth bit of 1 marks an address frame, and a ninth bit of 0 marks a data frame. The filter holds a node address register and a node mask register, both written through a small register port. It compares every address frame against two patterns:

- a masked node pattern, in which only the bit positions with a mask bit of 1 must agree with the stored address;
- a broadcast pattern, formed as address OR mask, in which only the bit positions with a 1 must be 1 in the received byte.

A hit on either pattern produces a single-cycle match pulse and selects the node. While the node is selected, data frames pass to the output. A miss on a later address frame deselects the node.

Out of reset both registers hold zero. Every bit is then a don't-care, so any address selects the node and filtering is in effect off. Several nodes may be given the same address. One address frame then selects all of them together.

Top module: `mp_addr_filter`

## Requirements
- R1: After reset the address and mask registers are 0x00 and node_selected is 0. In that state every address frame raises match_pulse.
- R2: A write with cfg_wr_en=1 loads cfg_wdata into the address register when cfg_sel=0, or into the mask register when cfg_sel=1. The new value takes effect from the next cycle. An address frame arriving in the same cycle as a write is compared against the old register values.
- R3: An address frame hits the node pattern when, at every bit position where the mask is 1, the received bit equals the address bit.
- R4: An address frame hits the broadcast pattern when, at every bit position where (address OR mask) is 1, the received bit is 1.
- R5: match_pulse is 1 in the same cycle as rx_valid, only for an address frame (rx_bit9=1) that hits R3 or R4. It is 0 in every other cycle.
- R6: Every address frame updates node_selected, which is visible from the next cycle: 1 on a hit, 0 on a miss.
- R7: A data frame (rx_valid=1, rx_bit9=0) is forwarded while node_selected is 1. Forwarding means data_valid_out=1 and data_out=rx_data in the same cycle. Otherwise data_valid_out=0 and data_out=0x00.
- R8: Data frames and idle cycles never raise match_pulse and never change node_selected, whatever their byte value.
- R9: With address 1111_0001 and mask 1111_1010, the node pattern is 1111_0X0X and the broadcast pattern is 1111_1X11. 0xF0, 0xF5, 0xFB and 0xFF hit. 0xF2, 0xF8 and 0x71 miss.
- R10: Two filters holding the same address and mask are selected together by one matching address frame, and deselected together by one missing address frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr_en | input | 1 | Register write strobe |
| cfg_sel | input | 1 | 0 selects the address register, 1 selects the mask register |
| cfg_wdata | input | 8 | Register write data |
| rx_valid | input | 1 | Received frame strobe |
| rx_data | input | 8 | Received byte |
| rx_bit9 | input | 1 | Ninth bit: 1 for an address frame, 0 for a data frame |
| match_pulse | output | 1 | One-cycle hit indication for an address frame |
| node_selected | output | 1 | Node currently selected |
| data_valid_out | output | 1 | Forwarded data frame strobe |
| data_out | output | 8 | Forwarded data byte, 0x00 when not forwarding |

## Verification
A register write and an address frame can arrive in the same cycle. The comparison must then use the register values from before the write. The bench provokes this by writing the mask to 0xFF while it sends an address frame that only the old all-don't-care mask accepts. The scoreboard expects a hit in that cycle and a miss for the same byte one frame later. A selection update and a data frame never share a cycle, because the selection flag is registered. The bench confirms this by sending a data frame directly after each address frame and checking that forwarding follows the flag as it was already updated.

// File: rtl/mpf_pkg.sv
package mpf_pkg;
    localparam int unsigned BYTE_W = 8;

    typedef struct packed {
        logic [BYTE_W-1:0] addr;
        logic [BYTE_W-1:0] mask;
    } mpf_cfg_t;

    typedef enum logic {
        SEL_ADDR = 1'b0,
        SEL_MASK = 1'b1
    } mpf_reg_sel_e;
endpackage

// File: rtl/mpf_cfg_regs.sv
module mpf_cfg_regs
    import mpf_pkg::*;
#(
    parameter int unsigned W = BYTE_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_en,
    input  logic         wr_sel,
    input  logic [W-1:0] wr_data,
    output logic [W-1:0] addr_o,
    output logic [W-1:0] mask_o
);
    typedef struct packed {
        logic [W-1:0] addr;
        logic [W-1:0] mask;
    } regs_t;

    regs_t regs_d, regs_q;

    always_comb begin
        regs_d = regs_q;
        if (wr_en) begin
            if (mpf_reg_sel_e'(wr_sel) == SEL_ADDR) begin
                regs_d.addr = wr_data;
            end else begin
                regs_d.mask = wr_data;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            regs_q <= '0;
        end else begin
            regs_q <= regs_d;
        end
    end

    assign addr_o = regs_q.addr;
    assign mask_o = regs_q.mask;

    // R2: a write lands in the selected register only
    a_r2_addr_write: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wr_sel) |=> (addr_o == $past(wr_data)) && $stable(mask_o));
    a_r2_mask_write: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_sel) |=> (mask_o == $past(wr_data)) && $stable(addr_o));
    a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(addr_o) && $stable(mask_o));
endmodule

// File: rtl/mpf_addr_match.sv
module mpf_addr_match #(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] addr_i,
    input  logic [W-1:0] mask_i,
    input  logic [W-1:0] rx_byte_i,
    output logic         node_hit_o,
    output logic         bcast_hit_o,
    output logic         hit_o
);
    logic [W-1:0] bcast_pat;
    logic [W-1:0] node_diff;
    logic [W-1:0] bcast_miss;

    always_comb begin
        bcast_pat  = addr_i | mask_i;
        node_diff  = (rx_byte_i ^ addr_i) & mask_i;
        bcast_miss = bcast_pat & ~rx_byte_i;
    end

    assign node_hit_o  = (node_diff == '0);
    assign bcast_hit_o = (bcast_miss == '0);
    assign hit_o       = node_hit_o | bcast_hit_o;

    // R1: all-zero registers make every bit a don't-care
    a_r1_all_pass: assert property (@(posedge clk) disable iff (!rst_n)
        (addr_i == '0 && mask_i == '0) |-> hit_o);
    // R4: an all-ones byte always satisfies the broadcast pattern
    a_r4_ones_bcast: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_byte_i == '1) |-> bcast_hit_o);
    // R3: a byte equal to the stored address always satisfies the node pattern
    a_r3_self_hit: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_byte_i == addr_i) |-> node_hit_o);
endmodule

// File: rtl/mpf_select.sv
module mpf_select #(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         rx_valid,
    input  logic         rx_bit9,
    input  logic [W-1:0] rx_data,
    input  logic         hit,
    output logic         match_pulse,
    output logic         selected,
    output logic         fwd_valid,
    output logic [W-1:0] fwd_data
);
    typedef struct packed {
        logic sel;
    } sel_state_t;

    sel_state_t st_d, st_q;
    logic       is_addr_frame;
    logic       is_data_frame;

    always_comb begin
        is_addr_frame = rx_valid & rx_bit9;
        is_data_frame = rx_valid & ~rx_bit9;
        st_d          = st_q;
        if (is_addr_frame) begin
            st_d.sel = hit;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign match_pulse = is_addr_frame & hit;
    assign selected    = st_q.sel;
    assign fwd_valid   = is_data_frame & st_q.sel;
    assign fwd_data    = fwd_valid ? rx_data : '0;

    // R6: address frames set or clear the selection on the next cycle
    a_r6_set: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && rx_bit9 && hit) |=> selected);
    a_r6_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && rx_bit9 && !hit) |=> !selected);
    // R8: anything other than an address frame keeps the selection
    a_r8_keep: assert property (@(posedge clk) disable iff (!rst_n)
        !(rx_valid && rx_bit9) |=> $stable(selected));
endmodule

// File: rtl/mp_addr_filter.sv
module mp_addr_filter
    import mpf_pkg::*;
#(
    parameter int unsigned W = BYTE_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         cfg_wr_en,
    input  logic         cfg_sel,
    input  logic [W-1:0] cfg_wdata,
    input  logic         rx_valid,
    input  logic [W-1:0] rx_data,
    input  logic         rx_bit9,
    output logic         match_pulse,
    output logic         node_selected,
    output logic         data_valid_out,
    output logic [W-1:0] data_out
);
    logic [W-1:0] addr_q;
    logic [W-1:0] mask_q;
    logic         node_hit;
    logic         bcast_hit;
    logic         any_hit;

    mpf_cfg_regs #(.W(W)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (cfg_wr_en),
        .wr_sel  (cfg_sel),
        .wr_data (cfg_wdata),
        .addr_o  (addr_q),
        .mask_o  (mask_q)
    );

    mpf_addr_match #(.W(W)) u_match (
        .clk         (clk),
        .rst_n       (rst_n),
        .addr_i      (addr_q),
        .mask_i      (mask_q),
        .rx_byte_i   (rx_data),
        .node_hit_o  (node_hit),
        .bcast_hit_o (bcast_hit),
        .hit_o       (any_hit)
    );

    mpf_select #(.W(W)) u_sel (
        .clk         (clk),
        .rst_n       (rst_n),
        .rx_valid    (rx_valid),
        .rx_bit9     (rx_bit9),
        .rx_data     (rx_data),
        .hit         (any_hit),
        .match_pulse (match_pulse),
        .selected    (node_selected),
        .fwd_valid   (data_valid_out),
        .fwd_data    (data_out)
    );

    // R5: pulses only accompany address frames
    a_r5_pulse_addr_only: assert property (@(posedge clk) disable iff (!rst_n)
        match_pulse |-> (rx_valid && rx_bit9));
    // R7: forwarded data is never an address frame
    a_r7_fwd_data_only: assert property (@(posedge clk) disable iff (!rst_n)
        data_valid_out |-> (rx_valid && !rx_bit9 && !match_pulse));
endmodule

// File: tb/test_mp_addr_filter.sv
module test_mp_addr_filter;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_wr_en = 1'b0, cfg_sel = 1'b0;
    logic [7:0] cfg_wdata = 8'h00;
    logic       rx_valid = 1'b0, rx_bit9 = 1'b0;
    logic [7:0] rx_data = 8'h00;
    logic       match_pulse, node_selected, data_valid_out;
    logic [7:0] data_out;
    logic       p_wr_en = 1'b0, p_sel = 1'b0;
    logic [7:0] p_wdata = 8'h00;
    logic       p_match, p_selected, p_dv;
    logic [7:0] p_dout;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    typedef struct {
        bit       m;
        bit       dv;
        bit [7:0] dout;
        bit       sel;
        string    req;
    } exp_t;
    exp_t q[$];

    bit [7:0] ref_addr = 8'h00;
    bit [7:0] ref_mask = 8'h00;
    bit       ref_sel = 1'b0;

    always #10 clk = ~clk;

    mp_addr_filter i_mp_addr_filter (
        .clk(clk), .rst_n(rst_n), .cfg_wr_en(cfg_wr_en), .cfg_sel(cfg_sel),
        .cfg_wdata(cfg_wdata), .rx_valid(rx_valid), .rx_data(rx_data),
        .rx_bit9(rx_bit9), .match_pulse(match_pulse), .node_selected(node_selected),
        .data_valid_out(data_valid_out), .data_out(data_out)
    );

    mp_addr_filter i_mp_addr_filter_peer (
        .clk(clk), .rst_n(rst_n), .cfg_wr_en(p_wr_en), .cfg_sel(p_sel),
        .cfg_wdata(p_wdata), .rx_valid(rx_valid), .rx_data(rx_data),
        .rx_bit9(rx_bit9), .match_pulse(p_match), .node_selected(p_selected),
        .data_valid_out(p_dv), .data_out(p_dout)
    );

    task automatic check(string req, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic bit ref_hit(bit [7:0] d);
        bit [7:0] bc;
        bc = ref_addr | ref_mask;
        return (((d ^ ref_addr) & ref_mask) == 8'h00) || ((d & bc) == bc);
    endfunction

    task automatic drive(bit v, bit b9, bit [7:0] d, bit we, bit cs, bit [7:0] wd, string req);
        exp_t e;
        @(negedge clk);
        rx_valid  = v;
        rx_bit9   = b9;
        rx_data   = d;
        cfg_wr_en = we;
        cfg_sel   = cs;
        cfg_wdata = wd;
        e.sel  = ref_sel;
        e.m    = v && b9 && ref_hit(d);
        e.dv   = v && !b9 && ref_sel;
        e.dout = e.dv ? d : 8'h00;
        e.req  = req;
        q.push_back(e);
        if (v && b9) ref_sel = ref_hit(d);
        if (we) begin
            if (cs) ref_mask = wd;
            else    ref_addr = wd;
        end
    endtask

    task automatic send_addr(bit [7:0] d, string req);
        drive(1'b1, 1'b1, d, 1'b0, 1'b0, 8'h00, req);
    endtask
    task automatic send_data(bit [7:0] d, string req);
        drive(1'b1, 1'b0, d, 1'b0, 1'b0, 8'h00, req);
    endtask
    task automatic write_cfg(bit cs, bit [7:0] wd, string req);
        drive(1'b0, 1'b0, 8'h00, 1'b1, cs, wd, req);
    endtask
    task automatic idle(string req);
        drive(1'b0, 1'b0, 8'h00, 1'b0, 1'b0, 8'h00, req);
    endtask

    // monitor: one expected item per driven cycle
    initial begin
        exp_t e;
        forever begin
            @(negedge clk);
            #5;
            if (q.size() > 0) begin
                e = q.pop_front();
                check(e.req, "match_pulse", int'(match_pulse), int'(e.m));
                check(e.req, "node_selected", int'(node_selected), int'(e.sel));
                check(e.req, "data_valid_out", int'(data_valid_out), int'(e.dv));
                check(e.req, "data_out", int'(data_out), int'(e.dout));
            end
        end
    end

    initial begin
        #(20 * 100000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired actual=hung expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        #5;
        check("R1", "reset node_selected", int'(node_selected), 0);
        check("R1", "reset match_pulse", int'(match_pulse), 0);
        check("R1", "reset data_out", int'(data_out), 0);
        rst_n = 1'b1;

        // R1: transparent after reset
        send_addr(8'h5A, "R1");
        send_data(8'h33, "R7");
        send_addr(8'h00, "R1");
        send_data(8'hC4, "R7");

        // peer set to 0x22 / 0xFF for R10
        @(negedge clk);
        p_wr_en = 1'b1; p_sel = 1'b0; p_wdata = 8'h22;
        @(negedge clk);
        p_sel = 1'b1; p_wdata = 8'hFF;
        @(negedge clk);
        p_wr_en = 1'b0;

        // R2: write address, then mask in the same cycle as an address frame
        write_cfg(1'b0, 8'h22, "R2");
        drive(1'b1, 1'b1, 8'h77, 1'b1, 1'b1, 8'hFF, "R2");
        send_addr(8'h77, "R2");
        send_data(8'h10, "R7");

        // R3 node pattern, R6 selection update
        send_addr(8'h22, "R3");
        send_data(8'hA5, "R7");
        send_addr(8'h23, "R3");
        send_data(8'hA6, "R7");
        send_addr(8'hA2, "R6");

        // R4 broadcast
        send_addr(8'hFF, "R4");
        send_addr(8'hFE, "R4");
        send_addr(8'hFF, "R4");

        // R8: data and idle cycles do not touch selection
        send_data(8'h23, "R8");
        send_data(8'hFE, "R8");
        idle("R8");
        send_addr(8'h01, "R6");
        send_data(8'h22, "R8");
        send_data(8'hFF, "R8");
        idle("R8");

        // R5: pulse is one cycle wide
        send_addr(8'h22, "R5");
        idle("R5");

        // R10: both nodes hold 0x22 / 0xFF
        send_addr(8'h22, "R10");
        idle("R10");
        #5;
        check("R10", "main selected", int'(node_selected), 1);
        check("R10", "peer selected", int'(p_selected), 1);
        send_addr(8'h24, "R10");
        idle("R10");
        #5;
        check("R10", "main deselected", int'(node_selected), 0);
        check("R10", "peer deselected", int'(p_selected), 0);

        // R9: worked example
        write_cfg(1'b0, 8'hF1, "R9");
        write_cfg(1'b1, 8'hFA, "R9");
        send_addr(8'hF0, "R9");
        send_addr(8'hF2, "R9");
        send_addr(8'hF5, "R9");
        send_addr(8'hF8, "R9");
        send_addr(8'hFB, "R9");
        send_addr(8'h71, "R9");
        send_addr(8'hFF, "R9");
        send_data(8'h5C, "R9");
        idle("R9");

        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule